// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address in two steps. The top three bits pick one of eight on-chip segment entries. Each entry holds the base address of that segment's page table and the number of entries in that table. The middle 17 bits are a virtual page number. The unit checks that number against the segment's table length. If the number is in range, the unit reads one 32-bit page-table entry through a request/acknowledge memory port. It then joins the physical page number taken from that entry with the 12-bit page offset.

Software, or a neighbouring controller, loads the segment entries through a simple write port. Translations arrive on a valid/ready request interface. The unit works on one translation at a time and returns the result on a valid/ready response interface. An out-of-range page number ends the translation at once with an error flag and produces no memory traffic.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: The virtual address is split so that bits 31:29 are the segment index, bits 28:12 are the virtual page number and bits 11:0 are the offset.
- R3: If the virtual page number is greater than or equal to the selected segment's entry count, the response has rsp_err_o = 1 and rsp_paddr_o = 0, and mem_req_o is never raised for that translation.
- R4: For an in-range page number, mem_addr_o equals the segment base plus four times the page number, taken modulo 2^30.
- R5: Once mem_req_o is raised, it stays high and mem_addr_o stays unchanged until the cycle in which mem_ack_i is sampled high.
- R6: For a successful translation, rsp_paddr_o equals bits 17:0 of mem_rdata_i (as sampled with mem_ack_i) concatenated with the 12-bit offset, and rsp_err_o is 0. Bits 31:18 of the entry have no effect.
- R7: From acceptance until the response is taken, req_ready_o is 0. Each successful translation issues exactly one memory request.
- R8: While rsp_valid_o = 1 and rsp_ready_i = 0, the response stays valid and unchanged.
- R9: A segment write changes only the entry it addresses. It applies to translations accepted after the write.
- R10: An entry count of 0 rejects every page number. An entry count of 2^17 accepts every page number, including 131071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_wr_en_i | input | 1 | Segment entry write strobe |
| seg_wr_idx_i | input | 3 | Segment entry to write |
| seg_wr_base_i | input | 30 | Page-table base address to store |
| seg_wr_bound_i | input | 18 | Page-table entry count to store (0 to 2^17) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| mem_req_o | output | 1 | Page-table read request |
| mem_addr_o | output | 30 | Byte address of the page-table entry |
| mem_ack_i | input | 1 | Read acknowledge; mem_rdata_i is valid in this cycle |
| mem_rdata_i | input | 32 | Page-table entry read data |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_paddr_o | output | 30 | Physical address (zero on error) |
| rsp_err_o | output | 1 | Page number outside the segment's table |

## Verification
The assertions assume that the memory side raises mem_ack_i only while mem_req_o is high, for exactly one cycle, and that mem_rdata_i is meaningful only in that cycle. They also assume that segment entries are not rewritten while a translation is in flight. The bench's memory model waits for a request, holds it for 0 to 2 cycles, acknowledges once and then drops the acknowledge. Segment writes are issued only while req_ready_o is high. The sweep covers every segment with entry counts at 0, 1 and 2^17, and with page numbers at 0, at the last valid entry, at the first invalid entry and beyond it. Response back-pressure is varied throughout.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int unsigned SEG_W_DEF = 3;
  localparam int unsigned VPN_W_DEF = 17;
  localparam int unsigned OFF_W_DEF = 12;
  localparam int unsigned PPN_W_DEF = 18;
  localparam int unsigned PA_W_DEF  = 30;
  localparam int unsigned PTE_W_DEF = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_RESP
  } spx_state_e;
endpackage

// File: rtl/spx_seg_file.sv
module spx_seg_file #(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned PA_W  = 30,
  parameter int unsigned BND_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [BND_W-1:0] wr_bound_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [BND_W-1:0] rd_bound_o
);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [BND_W-1:0] bound_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    // reset count of zero: every lookup faults until programmed
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == SEG_W'(g))) begin
        base_q[g]  <= wr_base_i;
        bound_q[g] <= wr_bound_i;
      end
    end
  end

  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_bound_o = bound_q[rd_idx_i];
endmodule

// File: rtl/spx_bound_addr.sv
module spx_bound_addr #(
  parameter int unsigned VPN_W  = 17,
  parameter int unsigned PA_W   = 30,
  parameter int unsigned BND_W  = 18,
  parameter int unsigned PTE_W  = 32
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [BND_W-1:0] bound_i,
  output logic             err_o,
  output logic [PA_W-1:0]  pte_addr_o
);
  localparam int unsigned PTE_SHIFT = $clog2(PTE_W / 8);

  logic [PA_W-1:0] scaled;

  assign err_o      = BND_W'(vpn_i) >= bound_i;
  assign scaled     = PA_W'(vpn_i) << PTE_SHIFT;
  assign pte_addr_o = base_i + scaled;
endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl
  import spx_pkg::*;
#(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned VPN_W = 17,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PPN_W = 18,
  parameter int unsigned PA_W  = 30,
  parameter int unsigned VA_W  = SEG_W + VPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic [SEG_W-1:0] seg_idx_o,
  output logic [VPN_W-1:0] vpn_o,
  input  logic             chk_err_i,
  input  logic [PA_W-1:0]  chk_addr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PPN_W-1:0] mem_ppn_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_err_o
);
  spx_state_e       state_q;
  logic [SEG_W-1:0] seg_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  addr_q;
  logic [PPN_W-1:0] ppn_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      ppn_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          seg_q   <= req_vaddr_i[VA_W-1 -: SEG_W];
          vpn_q   <= req_vaddr_i[OFF_W +: VPN_W];
          off_q   <= req_vaddr_i[OFF_W-1:0];
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          // segment lookup done this cycle; fault skips the memory read
          err_q   <= chk_err_i;
          addr_q  <= chk_addr_i;
          state_q <= chk_err_i ? ST_RESP : ST_FETCH;
        end
        ST_FETCH: if (mem_ack_i) begin
          ppn_q   <= mem_ppn_i;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = state_q == ST_IDLE;
  assign seg_idx_o   = seg_q;
  assign vpn_o       = vpn_q;
  assign mem_req_o   = state_q == ST_FETCH;
  assign mem_addr_o  = addr_q;
  assign rsp_valid_o = state_q == ST_RESP;
  assign rsp_err_o   = err_q;
  assign rsp_paddr_o = err_q ? '0 : {ppn_q, off_q};
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int unsigned SEG_W = SEG_W_DEF,
  parameter int unsigned VPN_W = VPN_W_DEF,
  parameter int unsigned OFF_W = OFF_W_DEF,
  parameter int unsigned PPN_W = PPN_W_DEF,
  parameter int unsigned PTE_W = PTE_W_DEF,
  localparam int unsigned VA_W  = SEG_W + VPN_W + OFF_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W,
  localparam int unsigned BND_W = VPN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_wr_en_i,
  input  logic [SEG_W-1:0] seg_wr_idx_i,
  input  logic [PA_W-1:0]  seg_wr_base_i,
  input  logic [BND_W-1:0] seg_wr_bound_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_err_o
);
  logic [SEG_W-1:0] seg_idx;
  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  seg_base;
  logic [BND_W-1:0] seg_bound;
  logic             chk_err;
  logic [PA_W-1:0]  chk_addr;
  logic             unused_pte_hi;

  // entry bits above the frame number are don't-care
  assign unused_pte_hi = ^mem_rdata_i[PTE_W-1:PPN_W];

  spx_seg_file #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_seg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (seg_wr_en_i),
    .wr_idx_i   (seg_wr_idx_i),
    .wr_base_i  (seg_wr_base_i),
    .wr_bound_i (seg_wr_bound_i),
    .rd_idx_i   (seg_idx),
    .rd_base_o  (seg_base),
    .rd_bound_o (seg_bound)
  );

  spx_bound_addr #(.VPN_W(VPN_W), .PA_W(PA_W), .BND_W(BND_W), .PTE_W(PTE_W)) u_chk (
    .vpn_i      (vpn),
    .base_i     (seg_base),
    .bound_i    (seg_bound),
    .err_o      (chk_err),
    .pte_addr_o (chk_addr)
  );

  spx_ctrl #(
    .SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_vaddr_i (req_vaddr_i),
    .seg_idx_o   (seg_idx),
    .vpn_o       (vpn),
    .chk_err_i   (chk_err),
    .chk_addr_i  (chk_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_ppn_i   (mem_rdata_i[PPN_W-1:0]),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_err_o   (rsp_err_o)
  );
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PPN_W = 18,
  parameter int unsigned PA_W  = 30,
  parameter int unsigned PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             mem_req_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             mem_ack_i,
  input logic [PTE_W-1:0] mem_rdata_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             rsp_err_o
);
  logic             mem_seen_q;
  logic [OFF_W-1:0] off_q;
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_seen_q <= 1'b0;
      off_q      <= '0;
      ppn_q      <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        mem_seen_q <= 1'b0;
        off_q      <= req_vaddr_i[OFF_W-1:0];
      end else if (mem_req_o && mem_ack_i) begin
        mem_seen_q <= 1'b1;
        ppn_q      <= mem_rdata_i[PPN_W-1:0];
      end
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_rsp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_err_o));

  assert_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  assert_fault_no_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> !mem_seen_q && rsp_paddr_o == '0);

  assert_ok_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o |-> mem_seen_q);

  assert_paddr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o |-> rsp_paddr_o == {ppn_q, off_q});
endmodule

bind seg_page_xlate spx_checker #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W), .PTE_W(PTE_W)
) u_spx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_vaddr_i (req_vaddr_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .mem_rdata_i (mem_rdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/seg_page_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_wr_en_i = 1'b0;
  logic [2:0]  seg_wr_idx_i = '0;
  logic [29:0] seg_wr_base_i = '0;
  logic [17:0] seg_wr_bound_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = 32'hDEAD_BEEF;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [29:0] rsp_paddr_o;
  logic        rsp_err_o;

  int checks = 0;
  int errors = 0;
  int mem_cnt = 0;
  logic [29:0] last_addr = '0;
  logic [29:0] base_m [8];
  logic [17:0] bnd_m [8];

  always #2 clk_i = ~clk_i;

  seg_page_xlate dut_i (.*);

  function automatic logic [31:0] pte_of(input logic [29:0] a);
    return {14'h3ABC, a[19:2] ^ 18'h2C3A5};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: 0..2 cycle wait, single-cycle ack; checks R5 while waiting
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_req_o) begin
        automatic logic [29:0] a = mem_addr_o;
        automatic int d = mem_cnt % 3;
        mem_cnt++;
        last_addr = a;
        for (int i = 0; i < d; i++) begin
          @(negedge clk_i);
          check(mem_req_o && mem_addr_o == a, "R5", "request held",
                {1'b0, mem_req_o, mem_addr_o}, {2'b01, a});
        end
        mem_ack_i = 1'b1;
        mem_rdata_i = pte_of(a);
        @(negedge clk_i);
        mem_ack_i = 1'b0;
        mem_rdata_i = 32'hDEAD_BEEF;
      end
    end
  end

  task automatic seg_write(input logic [2:0] s, input logic [29:0] b, input logic [17:0] n);
    @(negedge clk_i);
    seg_wr_en_i = 1'b1; seg_wr_idx_i = s; seg_wr_base_i = b; seg_wr_bound_i = n;
    base_m[s] = b; bnd_m[s] = n;
    @(negedge clk_i);
    seg_wr_en_i = 1'b0;
  endtask

  task automatic xlate(input logic [2:0] s, input logic [16:0] v, input logic [11:0] o,
                       input int stall, input string req);
    logic [29:0] exp_addr, got_pa;
    logic        exp_err, got_err;
    int          cnt0;
    exp_addr = base_m[s] + {11'b0, v, 2'b00};
    exp_err  = {1'b0, v} >= bnd_m[s];
    cnt0     = mem_cnt;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = {s, v, o};
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_vaddr_i = ~req_vaddr_i;
    while (!rsp_valid_o) begin
      check(!req_ready_o, "R7", "ready low while busy", {31'b0, req_ready_o}, 32'd0);
      @(negedge clk_i);
    end
    got_pa = rsp_paddr_o; got_err = rsp_err_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      check(rsp_valid_o && rsp_paddr_o == got_pa && rsp_err_o == got_err, "R8",
            "response held", {1'b0, rsp_valid_o, rsp_paddr_o}, {2'b01, got_pa});
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    check(req_ready_o && !rsp_valid_o, "R7", "idle after response",
          {30'b0, req_ready_o, rsp_valid_o}, 32'd2);
    check(got_err == exp_err, req, "error flag", {31'b0, got_err}, {31'b0, exp_err});
    if (exp_err) begin
      check(mem_cnt == cnt0, req, "no read on fault", mem_cnt - cnt0, 0);
      check(got_pa == '0, req, "paddr zero on fault", {2'b0, got_pa}, 32'd0);
    end else begin
      check(mem_cnt == cnt0 + 1, "R7", "one read", mem_cnt - cnt0, 1);
      check(last_addr == exp_addr, "R4", "entry address", {2'b0, last_addr}, {2'b0, exp_addr});
      check(got_pa == {pte_of(exp_addr)[17:0], o}, "R6", "physical address",
            {2'b0, got_pa}, {2'b0, pte_of(exp_addr)[17:0], o});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] bnds [8];
    logic [29:0] bases [8];
    bnds  = '{18'd0, 18'd1, 18'd2, 18'd5, 18'd17, 18'h20000, 18'd1000, 18'd3};
    bases = '{30'h0000_1000, 30'h0123_4560, 30'h0ABC_0000, 30'h1000_0004,
              30'h2222_2220, 30'h3FFF_F000, 30'h0000_0000, 30'h1555_5550};
    for (int s = 0; s < 8; s++) begin base_m[s] = '0; bnd_m[s] = '0; end
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !rsp_valid_o && !mem_req_o, "R1", "reset outputs",
          {29'b0, req_ready_o, rsp_valid_o, mem_req_o}, 32'd4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && !rsp_valid_o && !mem_req_o, "R1", "after release",
          {29'b0, req_ready_o, rsp_valid_o, mem_req_o}, 32'd4);
    // unprogrammed entries have count 0 -> fault (R10)
    xlate(3'd4, 17'd0, 12'h123, 0, "R10");
    for (int s = 0; s < 8; s++) seg_write(3'(s), bases[s], bnds[s]);
    // sweep every segment around its boundary (R2 field split, R3/R10 bound)
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 6; k++) begin
        automatic int v;
        automatic logic [11:0] o = 12'((s * 37 + k * 113) ^ (k == 0 ? 12'hFFF : 12'h0));
        case (k)
          0: v = 0;
          1: v = 1;
          2: v = int'(bnds[s]) - 1;
          3: v = int'(bnds[s]);
          4: v = int'(bnds[s]) + 1;
          default: v = 131071;
        endcase
        if (v >= 0 && v < 131072)
          xlate(3'(s), 17'(v), o, (s + k) % 3, (s == 0 || s == 5) ? "R10" : "R3");
      end
    end
    // R2: all-ones address fields land in segment 7, page 131071
    xlate(3'd7, 17'h1FFFF, 12'hFFF, 1, "R2");
    xlate(3'd5, 17'h1FFFF, 12'h000, 0, "R2");
    // R9: rewrite segment 2 only; segment 3 keeps its entry
    seg_write(3'd2, 30'h0765_4320, 18'd40);
    xlate(3'd2, 17'd39, 12'h0AB, 2, "R9");
    xlate(3'd2, 17'd40, 12'h0AB, 0, "R9");
    xlate(3'd3, 17'd4, 12'h555, 1, "R9");
    xlate(3'd3, 17'd5, 12'h555, 0, "R9");
    repeat (4) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule